// File: doc/BRIEF.md
# DRAM Refresh Sequencer with Row/Refresh Address Multiplexer

This block keeps a dynamic RAM array alive by stealing short slots from normal memory traffic. A free-running divider on the system clock raises a refresh request once per period. When no CPU memory cycle is in progress, the block drives its own active-low refresh row strobe for a fixed number of clocks, then waits out a precharge interval. During that time the multiplexed DRAM address bus carries the refresh row instead of the CPU row/column address. The refresh row comes from an 8-bit free-running counter, whose low 7 bits address the 128 rows. The counter steps once at the end of every refresh strobe.

A one-bit select register chooses between the CPU address and the refresh row. It flips to refresh when a refresh starts. It goes back to the CPU side halfway through precharge, so the next CPU address settles early. While the power-on input is high, the select is held on refresh and refresh cycles run back to back. A request that arrives while the CPU has a cycle in progress waits until that cycle ends. A busy output tells the CPU side that refresh owns the DRAM. The reset input is asynchronous active-low and must be released in step with the clock.

With the default divide ratio of 64 at about 4.9 MHz, a refresh starts every 13 µs. That is inside the 15.6 µs per row that a 2 ms, 128-row retention budget allows.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is asserted, the outputs are refresh strobe high (1), mux select on the memory side (0) and busy low.
- R2: With no CPU cycle and power-on low, the refresh strobe falls DIV_RATIO clocks after reset release, and every DIV_RATIO clocks after that.
- R3: The refresh strobe stays low for exactly RAS_LOW_CLKS clocks per refresh.
- R4: The mux select is 1 (refresh) from the clock edge at which the strobe falls. It returns to 0 exactly PRECHG_CLKS/2 clocks (rounded down) after the strobe rises, unless power-on is high.
- R5: While the select is 1, the address output equals the low 7 bits of the refresh row counter. Each refresh presents a row one higher (mod 128) than the previous refresh, because the counter advances when the strobe rises.
- R6: Reset does not clear the refresh row counter. The first refresh after a reset continues the row sequence.
- R7: While the select is 0, the address output equals the CPU row input when the column-phase input is 0, and the CPU column input when it is 1.
- R8: A request raised while the CPU-busy input is high is held. The strobe stays high while CPU-busy is high, and falls on the first clock edge after CPU-busy goes low.
- R9: While power-on is high, the select is 1 from the next clock edge onward. Refreshes repeat with the strobe falling PRECHG_CLKS+1 clocks after each rise, regardless of the timer.
- R10: Busy is high from the strobe's falling edge until PRECHG_CLKS clocks after the strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| pwr_on | input | 1 | Power-on hold: forces refresh select and continuous refresh |
| mem_busy | input | 1 | CPU memory cycle in progress; defers refresh start |
| cpu_row | input | 7 | CPU row address |
| cpu_col | input | 7 | CPU column address |
| col_phase | input | 1 | 0 selects CPU row, 1 selects CPU column |
| dram_addr | output | 7 | Multiplexed DRAM address |
| rfsh_ras_n | output | 1 | Active-low refresh row strobe |
| mux_rfsh | output | 1 | Address select state: 1 refresh, 0 memory |
| rfsh_busy | output | 1 | Refresh owns the DRAM (strobe low or precharge running) |

## Verification
The assertions take four things for granted. The CPU-busy and power-on inputs change only between clock edges. A CPU cycle never stays busy forever. PRECHG_CLKS is at least 2, so the release point falls strictly inside precharge. The row counter has some defined value, even if it is arbitrary. The stimulus drives every input on the falling clock edge. It holds CPU-busy for a bounded window across one timer request, and raises power-on only while the sequencer is idle. It never assumes the counter's starting row: the first observed row becomes the reference for all later steps.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RAS  = 2'd1,
    SQ_PRE  = 2'd2
  } rfsh_st_e;
endpackage

// File: rtl/rfsh_timer.sv
// Free-running divider; tick is high for one clock every DIV clocks.
module rfsh_timer #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == CW'(DIV - 1));
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: requests are isolated single-clock pulses
  a_r2_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/rfsh_row_ctr.sv
// Refresh row counter: deliberately left out of reset, steps on each strobe rise.
module rfsh_row_ctr #(
  parameter int CNT_W = 8,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] row
);
  logic [CNT_W-1:0] row_q, row_d;

  always_comb begin
    row_d = row_q;
    if (adv) row_d = row_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    row_q <= row_d;
  end

  assign row = row_q[AW-1:0];

  // R5: one step per strobe rise
  a_r5_row_steps: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> row_q == $past(row_q) + 1'b1);
  // R5/R6: no movement between refreshes
  a_r5_row_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(row_q));
endmodule

// File: rtl/rfsh_seq.sv
// Refresh sequencer: pending request, strobe low phase, precharge, mux select.
module rfsh_seq
  import dram_rfsh_pkg::*;
#(
  parameter int RAS_LOW = 4,
  parameter int PRECHG  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwr_on,
  input  logic mem_busy,
  output logic ras_n,
  output logic mux_sel,
  output logic busy,
  output logic row_adv
);
  localparam int HALF = PRECHG / 2;
  localparam int MAXC = (RAS_LOW > PRECHG) ? RAS_LOW : PRECHG;
  localparam int SW   = (MAXC > 1) ? $clog2(MAXC + 1) : 1;

  rfsh_st_e       st_q, st_d;
  logic [SW-1:0]  sub_q, sub_d;
  logic           pend_q, pend_d;
  logic           mux_q, mux_d;
  logic           start;

  always_comb begin
    st_d    = st_q;
    sub_d   = sub_q;
    start   = (st_q == SQ_IDLE) &&
              (pwr_on || ((pend_q || tick) && !mem_busy));
    row_adv = (st_q == SQ_RAS) && (sub_q == SW'(RAS_LOW - 1));

    case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d  = SQ_RAS;
          sub_d = '0;
        end
      end
      SQ_RAS: begin
        if (row_adv) begin
          st_d  = SQ_PRE;
          sub_d = '0;
        end else begin
          sub_d = sub_q + 1'b1;
        end
      end
      SQ_PRE: begin
        if (sub_q == SW'(PRECHG - 1)) begin
          st_d  = SQ_IDLE;
          sub_d = '0;
        end else begin
          sub_d = sub_q + 1'b1;
        end
      end
      default: begin
        st_d  = SQ_IDLE;
        sub_d = '0;
      end
    endcase

    pend_d = pend_q;
    if (start)     pend_d = 1'b0;
    else if (tick) pend_d = 1'b1;

    mux_d = mux_q;
    if (pwr_on || start)
      mux_d = 1'b1;
    else if (st_q == SQ_PRE && sub_q == SW'(HALF - 1))
      mux_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      sub_q  <= '0;
      pend_q <= 1'b0;
      mux_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sub_q  <= sub_d;
      pend_q <= pend_d;
      mux_q  <= mux_d;
    end
  end

  assign ras_n   = (st_q != SQ_RAS);
  assign busy    = (st_q != SQ_IDLE);
  assign mux_sel = mux_q;

  // R4: select already on refresh when the strobe falls
  a_r4_mux_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> mux_sel);
  // R8: no strobe may start while the CPU holds the bus
  a_r8_defer_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n && mem_busy && !pwr_on) |=> ras_n);
  // R9: power-on forces the refresh select
  a_r9_pwr_forces_mux: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_on |=> mux_sel);
  // R10: busy covers the whole strobe low phase
  a_r10_busy_covers: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> busy);
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int AW = 7
) (
  input  logic          sel_rfsh,
  input  logic          col_phase,
  input  logic [AW-1:0] rfsh_row,
  input  logic [AW-1:0] cpu_row,
  input  logic [AW-1:0] cpu_col,
  output logic [AW-1:0] addr
);
  always_comb begin
    if (sel_rfsh)       addr = rfsh_row;
    else if (col_phase) addr = cpu_col;
    else                addr = cpu_row;
  end
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int DIV_RATIO    = 64,
  parameter int RAS_LOW_CLKS = 4,
  parameter int PRECHG_CLKS  = 4,
  parameter int ROW_CNT_W    = 8,
  parameter int ADDR_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              mem_busy,
  input  logic [ADDR_W-1:0] cpu_row,
  input  logic [ADDR_W-1:0] cpu_col,
  input  logic              col_phase,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              rfsh_ras_n,
  output logic              mux_rfsh,
  output logic              rfsh_busy
);
  logic              tick;
  logic              row_adv;
  logic [ADDR_W-1:0] rfsh_row;

  rfsh_timer #(.DIV(DIV_RATIO)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  rfsh_seq #(.RAS_LOW(RAS_LOW_CLKS), .PRECHG(PRECHG_CLKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .pwr_on   (pwr_on),
    .mem_busy (mem_busy),
    .ras_n    (rfsh_ras_n),
    .mux_sel  (mux_rfsh),
    .busy     (rfsh_busy),
    .row_adv  (row_adv)
  );

  rfsh_row_ctr #(.CNT_W(ROW_CNT_W), .AW(ADDR_W)) u_row (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (row_adv),
    .row   (rfsh_row)
  );

  dram_addr_mux #(.AW(ADDR_W)) u_mux (
    .sel_rfsh  (mux_rfsh),
    .col_phase (col_phase),
    .rfsh_row  (rfsh_row),
    .cpu_row   (cpu_row),
    .cpu_col   (cpu_col),
    .addr      (dram_addr)
  );

  // R3: the strobe rise is also the row step
  a_r3_rise_steps_row: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rfsh_ras_n) |-> $past(row_adv));
endmodule

// File: tb/dram_refresh_ctrl_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_tb_top;
  localparam int DIV  = 64;
  localparam int RLOW = 4;
  localparam int PRE  = 4;
  localparam int HALF = PRE / 2;

  logic       clk = 1'b0;
  logic       rst_n, pwr_on, mem_busy, col_phase;
  logic [6:0] cpu_row, cpu_col, addr;
  logic       ras_n, mux, busy;

  always #4 clk = ~clk;

  dram_refresh_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .mem_busy(mem_busy),
    .cpu_row(cpu_row), .cpu_col(cpu_col), .col_phase(col_phase),
    .dram_addr(addr), .rfsh_ras_n(ras_n), .mux_rfsh(mux), .rfsh_busy(busy)
  );

  int cyc;
  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  int last_row;
  bit have_row = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Monitor: pops expected strobe-fall cycles and checks the timing around each refresh
  bit prev_ras = 1, prev_mux = 0, prev_busy = 0, trk = 0;
  int low_len = 0, s = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1; prev_mux = mux; prev_busy = 0; trk = 0; low_len = 0;
    end else begin
      if (prev_ras && !ras_n) begin
        if (exp_q.size() == 0) chk("R2 unexpected refresh start", cyc, -1);
        else                   chk("R2 refresh start cycle", cyc, exp_q.pop_front());
        chk("R4 select on refresh at fall", int'(mux), 1);
        chk("R10 busy at fall", int'(busy), 1);
        if (have_row) chk("R5 refresh row step", int'(addr), (last_row + 1) % 128);
        last_row = int'(addr);
        have_row = 1;
      end
      if (!ras_n) low_len++;
      if (!prev_ras && ras_n) begin
        chk("R3 strobe low length", low_len, RLOW);
        low_len = 0; s = 0; trk = 1;
      end else if (trk) begin
        s++;
      end
      if (trk && prev_mux && !mux) chk("R4 select release point", s, HALF);
      if (trk && prev_busy && !busy) begin
        chk("R10 busy end", s, PRE);
        trk = 0;
      end
      prev_ras = ras_n; prev_mux = mux; prev_busy = busy;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int r_before;
    rst_n = 0; pwr_on = 0; mem_busy = 0; col_phase = 0;
    cpu_row = 7'h15; cpu_col = 7'h2a;
    repeat (3) @(negedge clk);
    chk("R1 strobe in reset", int'(ras_n), 1);
    chk("R1 select in reset", int'(mux), 0);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R7 row phase", int'(addr), 'h15);
    col_phase = 1; #1;
    chk("R7 column phase", int'(addr), 'h2a);

    exp_q.push_back(64); exp_q.push_back(128); exp_q.push_back(192);
    rst_n = 1;
    wait_cyc(100);
    col_phase = 0; cpu_row = 7'h33; #1;
    chk("R7 row phase while running", int'(addr), 'h33);
    wait_cyc(205);
    chk("R2 all periodic starts seen", exp_q.size(), 0);

    // R6: reset mid-run, CPU busy across the next timer request (R8)
    r_before = last_row;
    rst_n = 0; mem_busy = 1;
    repeat (2) @(negedge clk);
    chk("R1 strobe in second reset", int'(ras_n), 1);
    chk("R1 select in second reset", int'(mux), 0);
    exp_q.push_back(81); exp_q.push_back(128);
    rst_n = 1;
    wait_cyc(70);
    chk("R8 strobe held while CPU busy", int'(ras_n), 1);
    chk("R8 busy low while deferred", int'(busy), 0);
    wait_cyc(80);
    mem_busy = 0;
    wait_cyc(82);
    chk("R6 row continues across reset", last_row, (r_before + 1) % 128);

    // R9: power-on hold
    wait_cyc(140);
    pwr_on = 1;
    for (int k = 0; k < 6; k++) exp_q.push_back(141 + 9 * k);
    exp_q.push_back(195); exp_q.push_back(256);
    wait_cyc(141);
    chk("R9 select forced", int'(mux), 1);
    wait_cyc(166);
    chk("R9 select held", int'(mux), 1);
    wait_cyc(187);
    pwr_on = 0;

    wait_cyc(240);
    col_phase = 1; cpu_col = 7'h4c; #1;
    chk("R7 column phase after power-on", int'(addr), 'h4c);
    wait_cyc(270);
    chk("R2 R9 all starts seen", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule